// File: doc/BRIEF.md
# I/O Window Decoder with Resource Routing

This block sits behind a 10-bit ISA I/O bus and decides which of several logical devices owns each I/O cycle. Every device owns an 8-byte window whose base address is programmed at run time, can be switched on or off with an activate bit, and has its interrupt and DMA-request lines steered to one of sixteen bus lines by 4-bit select fields. The configuration arrives as parallel input values and is copied into shadow registers when `cfg_we` is high. This keeps a half-written setup out of the decode.

A small bus-cycle state machine samples AEN, IOR# and IOW# on every clock. It has six states. `ST_IDLE` means no command. `ST_RD_START` and `ST_WR_START` are the first cycle of a read or write. `ST_RD_HOLD` and `ST_WR_HOLD` are the rest of that command. `ST_DMA` covers the time AEN is high.

The transitions work as follows:
- AEN high sends every state to `ST_DMA`.
- From `ST_IDLE` or `ST_DMA`, a lone active IOR# enters `ST_RD_START` and a lone active IOW# enters `ST_WR_START`. Anything else returns to `ST_IDLE`.
- A start state moves to its hold state while the same command stays asserted. It stays in the hold state as long as that command stays asserted.
- When the command ends, the machine re-decodes the bus as from idle. It can go straight into the other command's start state.

The owning device and the offset are captured on entry to a start state. Each command yields a one-clock strobe in the cycle after the command is first seen.

Top module: `ldd_decoder`

## Requirements
- R1: While `isa_aen` is high, no read or write strobe asserts, whatever IOR#, IOW# and the address do.
- R2: A read (IOR# low, IOW# high) whose address falls in an active device's window produces `rd_stb` with that device's bit set, one clock after the command is first sampled. `reg_ofs` then equals address bits [2:0] and holds until the next command starts.
- R3: A write (IOW# low, IOR# high) to an active device's window produces `wr_stb` for that device with the same timing, and `reg_ofs` equal to address bits [2:0].
- R4: A device whose activate bit is 0 claims no cycles, and its interrupt is not driven onto any line.
- R5: The base is the 16-bit value {high byte, low byte} with bits [2:0] ignored. The window covers exactly the 8 addresses from that aligned base, and the addresses just below and just above it are not claimed.
- R6: A base whose aligned value is below 0x100 or above 0xFFF never matches. Aligned bases 0x100 and 0xFF8 are both valid.
- R7: Only address bits 9..3 are compared with base bits 9..3, so a base above 0x3FF aliases onto the 10-bit bus. For example, base 0x5A8 claims 0x1A8.
- R8: If active windows overlap, the lowest-numbered device wins. At most one bit of `rd_stb` and `wr_stb` together is ever set.
- R9: `irq_out[k]` is high when an active device has IRQ select k ≠ 0 and its `dev_irq` is high. Select 0 routes nowhere, and `irq_out[0]` stays low.
- R10: `drq_out[k]` is high when any device has DRQ select k and its `dev_drq` is high. Select 0 is line 0, and this routing does not depend on the activate bit.
- R11: After reset, every base, activate and IRQ select is 0. The DRQ select of device 1 is 4 and all other DRQ selects are 0. Strobes and `reg_ofs` are 0. Changing the configuration inputs has no effect until `cfg_we` is high at a clock edge.
- R12: Each read or write command gives exactly one strobe pulse however long it is held. A cycle with IOR# and IOW# both low gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isa_addr | input | 10 | I/O address A9..A0 |
| isa_aen | input | 1 | High during DMA cycles; blocks I/O decode |
| isa_ior_n | input | 1 | Active-low I/O read command |
| isa_iow_n | input | 1 | Active-low I/O write command |
| cfg_we | input | 1 | Loads all configuration inputs into the shadow registers |
| cfg_base_hi | input | N_DEV*8 | Base address high byte per device |
| cfg_base_lo | input | N_DEV*8 | Base address low byte per device |
| cfg_active | input | N_DEV | Activate bit per device |
| cfg_irq_sel | input | N_DEV*4 | IRQ line select per device (0 = unrouted) |
| cfg_drq_sel | input | N_DEV*4 | DRQ line select per device |
| dev_irq | input | N_DEV | Interrupt request from each device controller |
| dev_drq | input | N_DEV | DMA request from each device controller |
| rd_stb | output | N_DEV | One-hot, one-clock read strobe per device |
| wr_stb | output | N_DEV | One-hot, one-clock write strobe per device |
| reg_ofs | output | 3 | Register offset inside the claimed window |
| irq_out | output | 16 | Routed interrupt lines |
| drq_out | output | 16 | Routed DMA request lines |

## Verification
The bench builds the block with its defaults: three devices, a 10-bit address, 8-byte windows and 4-bit selects giving sixteen lines. Three devices are enough to set up a two-way overlap while a third device sits at an aliased base, and to test priority both with the winner active and with it switched off. The 10-bit address with a 16-bit base brings aliasing within reach, together with both range edges (below 0x100, at 0xFF8, and past 0xFFF). Sixteen lines let IRQ select 0 be shown as unrouted while DRQ select 0 still drives line 0.

// File: rtl/ldd_pkg.sv
package ldd_pkg;

    localparam int BASE_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_START,
        ST_RD_HOLD,
        ST_WR_START,
        ST_WR_HOLD,
        ST_DMA
    } bus_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_RD,
        CMD_WR,
        CMD_DMA
    } bus_cmd_e;

endpackage

// File: rtl/ldd_window_match.sv
module ldd_window_match
    import ldd_pkg::*;
#(
    parameter int                ADDR_W   = 10,
    parameter int                WIN_BITS = 3,
    parameter logic [BASE_W-1:0] BASE_MIN = 16'h0100,
    parameter logic [BASE_W-1:0] BASE_MAX = 16'h0FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic              active,
    output logic              hit
);

    logic [BASE_W-1:0] base_aligned;
    logic              in_range;
    logic              same_window;

    always_comb begin
        base_aligned = {base[BASE_W-1:WIN_BITS], {WIN_BITS{1'b0}}};
        in_range     = (base_aligned >= BASE_MIN) && (base_aligned <= BASE_MAX);
        same_window  = (addr[ADDR_W-1:WIN_BITS] == base[ADDR_W-1:WIN_BITS]);
        hit          = active && in_range && same_window;
    end

endmodule

// File: rtl/ldd_priority.sv
module ldd_priority #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic taken;

    // lowest index wins
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ldd_route.sv
module ldd_route #(
    parameter int N           = 3,
    parameter int SEL_W       = 4,
    parameter bit ZERO_IS_OFF = 1'b1,
    localparam int LINES      = 1 << SEL_W
) (
    input  logic [N-1:0]       src,
    input  logic [N-1:0]       en,
    input  logic [N*SEL_W-1:0] sel,
    output logic [LINES-1:0]   lines
);

    logic [SEL_W-1:0] pick;

    always_comb begin
        lines = '0;
        pick  = '0;
        for (int d = 0; d < N; d++) begin
            pick = sel[d*SEL_W +: SEL_W];
            if (src[d] && en[d]) begin
                if (!(ZERO_IS_OFF && (pick == '0))) begin
                    lines[pick] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ldd_decoder.sv
module ldd_decoder
    import ldd_pkg::*;
#(
    parameter int                  N_DEV     = 3,
    parameter int                  ADDR_W    = 10,
    parameter int                  WIN_BITS  = 3,
    parameter int                  SEL_W     = 4,
    parameter logic [BASE_W-1:0]   BASE_MIN  = 16'h0100,
    parameter logic [BASE_W-1:0]   BASE_MAX  = 16'h0FFF,
    parameter logic [N_DEV*SEL_W-1:0] DRQ_RESET = 12'h040,
    localparam int LINES = 1 << SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      isa_addr,
    input  logic                   isa_aen,
    input  logic                   isa_ior_n,
    input  logic                   isa_iow_n,
    input  logic                   cfg_we,
    input  logic [N_DEV*8-1:0]     cfg_base_hi,
    input  logic [N_DEV*8-1:0]     cfg_base_lo,
    input  logic [N_DEV-1:0]       cfg_active,
    input  logic [N_DEV*SEL_W-1:0] cfg_irq_sel,
    input  logic [N_DEV*SEL_W-1:0] cfg_drq_sel,
    input  logic [N_DEV-1:0]       dev_irq,
    input  logic [N_DEV-1:0]       dev_drq,
    output logic [N_DEV-1:0]       rd_stb,
    output logic [N_DEV-1:0]       wr_stb,
    output logic [WIN_BITS-1:0]    reg_ofs,
    output logic [LINES-1:0]       irq_out,
    output logic [LINES-1:0]       drq_out
);

    // shadow configuration
    logic [BASE_W-1:0]      base_q [N_DEV];
    logic [N_DEV-1:0]       act_q;
    logic [N_DEV*SEL_W-1:0] irq_sel_q;
    logic [N_DEV*SEL_W-1:0] drq_sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < N_DEV; d++) begin
                base_q[d] <= '0;
            end
            act_q     <= '0;
            irq_sel_q <= '0;
            drq_sel_q <= DRQ_RESET;
        end else if (cfg_we) begin
            for (int d = 0; d < N_DEV; d++) begin
                base_q[d] <= {cfg_base_hi[d*8 +: 8], cfg_base_lo[d*8 +: 8]};
            end
            act_q     <= cfg_active;
            irq_sel_q <= cfg_irq_sel;
            drq_sel_q <= cfg_drq_sel;
        end
    end

    // window compare per device, then fixed priority
    logic [N_DEV-1:0] hit_raw;
    logic [N_DEV-1:0] hit_gnt;

    for (genvar g = 0; g < N_DEV; g++) begin : g_win
        ldd_window_match #(
            .ADDR_W   (ADDR_W),
            .WIN_BITS (WIN_BITS),
            .BASE_MIN (BASE_MIN),
            .BASE_MAX (BASE_MAX)
        ) u_match (
            .addr   (isa_addr),
            .base   (base_q[g]),
            .active (act_q[g]),
            .hit    (hit_raw[g])
        );
    end

    ldd_priority #(.N(N_DEV)) u_prio (
        .req (hit_raw),
        .gnt (hit_gnt)
    );

    // bus command classification
    bus_cmd_e cmd_now;

    always_comb begin
        if (isa_aen) begin
            cmd_now = CMD_DMA;
        end else if (!isa_ior_n && isa_iow_n) begin
            cmd_now = CMD_RD;
        end else if (!isa_iow_n && isa_ior_n) begin
            cmd_now = CMD_WR;
        end else begin
            cmd_now = CMD_NONE;
        end
    end

    // state machine
    bus_state_e state_q;
    bus_state_e state_d;
    bus_state_e launch;
    logic       start_d;

    always_comb begin
        unique case (cmd_now)
            CMD_DMA: launch = ST_DMA;
            CMD_RD:  launch = ST_RD_START;
            CMD_WR:  launch = ST_WR_START;
            default: launch = ST_IDLE;
        endcase

        unique case (state_q)
            ST_IDLE, ST_DMA: begin
                state_d = launch;
            end
            ST_RD_START, ST_RD_HOLD: begin
                state_d = (cmd_now == CMD_RD) ? ST_RD_HOLD : launch;
            end
            ST_WR_START, ST_WR_HOLD: begin
                state_d = (cmd_now == CMD_WR) ? ST_WR_HOLD : launch;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase

        start_d = (state_d == ST_RD_START) || (state_d == ST_WR_START);
    end

    logic [N_DEV-1:0]    hit_q;
    logic [WIN_BITS-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= '0;
            ofs_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_d) begin
                hit_q <= hit_gnt;
                ofs_q <= isa_addr[WIN_BITS-1:0];
            end
        end
    end

    // output process
    always_comb begin
        rd_stb  = '0;
        wr_stb  = '0;
        reg_ofs = ofs_q;
        unique case (state_q)
            ST_RD_START: rd_stb = hit_q;
            ST_WR_START: wr_stb = hit_q;
            default: begin
                rd_stb = '0;
                wr_stb = '0;
            end
        endcase
    end

    // resource routing
    ldd_route #(
        .N           (N_DEV),
        .SEL_W       (SEL_W),
        .ZERO_IS_OFF (1'b1)
    ) u_irq_route (
        .src   (dev_irq),
        .en    (act_q),
        .sel   (irq_sel_q),
        .lines (irq_out)
    );

    ldd_route #(
        .N           (N_DEV),
        .SEL_W       (SEL_W),
        .ZERO_IS_OFF (1'b0)
    ) u_drq_route (
        .src   (dev_drq),
        .en    ({N_DEV{1'b1}}),
        .sel   (drq_sel_q),
        .lines (drq_out)
    );

endmodule

// File: rtl/ldd_decoder_chk.sv
module ldd_decoder_chk #(
    parameter int N_DEV = 3,
    parameter int SEL_W = 4,
    localparam int LINES = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             isa_aen,
    input logic [N_DEV-1:0] rd_stb,
    input logic [N_DEV-1:0] wr_stb,
    input logic [LINES-1:0] irq_out,
    input logic [N_DEV-1:0] act_q
);

    p_dma_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        isa_aen |=> (rd_stb == '0 && wr_stb == '0));

    p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb, wr_stb}));

    p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_stb) |=> (rd_stb == '0));

    p_wr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |=> (wr_stb == '0));

    p_inactive_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((rd_stb | wr_stb) & ~$past(act_q)) == '0));

    p_irq_line0_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out[0] == 1'b0));

endmodule

bind ldd_decoder ldd_decoder_chk #(
    .N_DEV (N_DEV),
    .SEL_W (SEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .isa_aen (isa_aen),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .irq_out (irq_out),
    .act_q   (act_q)
);

// File: tb/ldd_decoder_bench.sv
module ldd_decoder_bench;

    localparam int N  = 3;
    localparam int SW = 4;
    localparam int LN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [9:0]      addr = '0;
    logic            aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1;
    logic            cfg_we = 1'b0;
    logic [N*8-1:0]  bh = '0, bl = '0;
    logic [N-1:0]    act = '0;
    logic [N*SW-1:0] isel = '0, dsel = '0;
    logic [N-1:0]    dirq = '0, ddrq = '0;

    logic [N-1:0]  rd_stb, wr_stb;
    logic [2:0]    ofs;
    logic [LN-1:0] irq_out, drq_out;

    ldd_decoder u_ldd_decoder (
        .clk(clk), .rst_n(rst_n), .isa_addr(addr), .isa_aen(aen),
        .isa_ior_n(ior_n), .isa_iow_n(iow_n), .cfg_we(cfg_we),
        .cfg_base_hi(bh), .cfg_base_lo(bl), .cfg_active(act),
        .cfg_irq_sel(isel), .cfg_drq_sel(dsel), .dev_irq(dirq), .dev_drq(ddrq),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_ofs(ofs),
        .irq_out(irq_out), .drq_out(drq_out)
    );

    int  total = 0, bad = 0;
    bit  done = 1'b0;

    task automatic chk(string req, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // behavioural reference model
    int m_base [N];
    int m_act  [N];
    int m_irq  [N];
    int m_drq  [N];
    int prev_cmd, cmd, win;
    int e_rd, e_wr, e_ofs;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < N; d++) begin
                m_base[d] = 0; m_act[d] = 0; m_irq[d] = 0;
                m_drq[d] = (d == 1) ? 4 : 0;
            end
            prev_cmd = 0; e_rd = 0; e_wr = 0; e_ofs = 0;
        end else begin
            cmd = aen ? 3 : (!ior_n && iow_n) ? 1 : (!iow_n && ior_n) ? 2 : 0;
            e_rd = 0; e_wr = 0;
            if ((cmd == 1 || cmd == 2) && cmd != prev_cmd) begin
                win = -1;
                for (int d = N - 1; d >= 0; d--) begin
                    if (m_act[d] != 0 && m_base[d] >= 256 && m_base[d] <= 4095 &&
                        ((m_base[d] % 1024) / 8) == (int'(addr) / 8))
                        win = d;
                end
                if (win >= 0) begin
                    if (cmd == 1) e_rd = 1 << win; else e_wr = 1 << win;
                end
                e_ofs = int'(addr) % 8;
            end
            prev_cmd = cmd;
            if (cfg_we) begin
                for (int d = 0; d < N; d++) begin
                    m_base[d] = int'(bh[d*8 +: 8]) * 256 + int'(bl[d*8 +: 8]);
                    m_act[d]  = int'(act[d]);
                    m_irq[d]  = int'(isel[d*SW +: SW]);
                    m_drq[d]  = int'(dsel[d*SW +: SW]);
                end
            end
        end
    end

    function automatic int exp_irq();
        int r = 0;
        for (int d = 0; d < N; d++)
            if (m_act[d] != 0 && dirq[d] && m_irq[d] != 0) r |= 1 << m_irq[d];
        return r;
    endfunction

    function automatic int exp_drq();
        int r = 0;
        for (int d = 0; d < N; d++)
            if (ddrq[d]) r |= 1 << m_drq[d];
        return r;
    endfunction

    // per-clock comparison and strobe capture
    int seen_rd = 0, seen_wr = 0, pulses = 0;

    always @(posedge clk) begin
        #15;
        if (rst_n && !done) begin
            chk("R2 rd_stb", int'(rd_stb), e_rd);
            chk("R3 wr_stb", int'(wr_stb), e_wr);
            chk("R2 reg_ofs", int'(ofs), e_ofs);
            chk("R9 irq_out", int'(irq_out), exp_irq());
            chk("R10 drq_out", int'(drq_out), exp_drq());
            seen_rd |= int'(rd_stb);
            seen_wr |= int'(wr_stb);
            if ((rd_stb | wr_stb) != '0) pulses++;
        end
    end

    task automatic clr();
        seen_rd = 0; seen_wr = 0; pulses = 0;
    endtask

    // kind: 1 read, 2 write, 3 both low
    task automatic io(int kind, int a, int hold);
        clr();
        @(negedge clk);
        addr  = 10'(a);
        ior_n = !(kind == 1 || kind == 3);
        iow_n = !(kind == 2 || kind == 3);
        repeat (hold) @(negedge clk);
        ior_n = 1'b1;
        iow_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg(int d, int base, int a, int i, int q);
        bh[d*8 +: 8]    = 8'(base >> 8);
        bl[d*8 +: 8]    = 8'(base);
        act[d]          = a[0];
        isel[d*SW +: SW] = 4'(i);
        dsel[d*SW +: SW] = 4'(q);
    endtask

    task automatic commit();
        @(negedge clk); cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 rd_stb reset", int'(rd_stb), 0);
        chk("R11 wr_stb reset", int'(wr_stb), 0);
        chk("R11 reg_ofs reset", int'(ofs), 0);
        ddrq = 3'b010; @(negedge clk);
        chk("R11 dev1 drq default line 4", int'(drq_out), 'h10);
        ddrq = 3'b001; @(negedge clk);
        chk("R10 drq select 0 is line 0", int'(drq_out), 'h1);
        dirq = 3'b111; @(negedge clk);
        chk("R11 irq unrouted after reset", int'(irq_out), 0);
        dirq = '0; ddrq = '0;
        io(1, 'h100, 2);
        chk("R11 no claim after reset", seen_rd, 0);

        // configure three devices
        cfg(0, 'h0100, 1, 3, 1);
        cfg(1, 'h012D, 1, 5, 6);
        cfg(2, 'h05A8, 1, 0, 0);
        commit();

        // R2 read, held three cycles
        io(1, 'h103, 3);
        chk("R2 read claim dev0", seen_rd, 'b001);
        chk("R2 offset", int'(ofs), 3);
        chk("R12 one pulse per read", pulses, 1);

        // R3 write
        io(2, 'h12F, 2);
        chk("R3 write claim dev1", seen_wr, 'b010);
        chk("R3 offset", int'(ofs), 7);

        // R5 window edges and ignored base low bits
        io(2, 'h127, 1);
        chk("R5 below window", seen_wr, 0);
        io(2, 'h130, 1);
        chk("R5 above window", seen_wr, 0);
        io(1, 'h128, 1);
        chk("R5 aligned base start", seen_rd, 'b010);

        // R7 aliasing
        io(1, 'h1A8, 1);
        chk("R7 alias of 0x5A8", seen_rd, 'b100);

        // R1 DMA cycle
        @(negedge clk); aen = 1'b1;
        io(1, 'h103, 2);
        chk("R1 no read during AEN", seen_rd, 0);
        io(2, 'h12A, 2);
        chk("R1 no write during AEN", seen_wr, 0);
        @(negedge clk); aen = 1'b0;

        // R12 both commands low
        io(3, 'h103, 2);
        chk("R12 both low rd", seen_rd, 0);
        chk("R12 both low wr", seen_wr, 0);

        // R9 / R10 routing
        dirq = 3'b111; ddrq = 3'b111; @(negedge clk);
        chk("R9 irq lines 3 and 5", int'(irq_out), 'h0028);
        chk("R10 drq lines 0 1 6", int'(drq_out), 'h0043);
        dirq = '0; ddrq = '0;

        // R11 inputs without cfg_we
        cfg(0, 'h0200, 1, 3, 1);
        io(1, 'h200, 1);
        chk("R11 unloaded base ignored", seen_rd, 0);
        io(1, 'h101, 1);
        chk("R11 old base kept", seen_rd, 'b001);
        cfg(0, 'h0100, 1, 3, 1);

        // R4 inactive device
        cfg(0, 'h0100, 0, 3, 1);
        commit();
        io(1, 'h103, 1);
        chk("R4 inactive no claim", seen_rd, 0);
        dirq = 3'b001; @(negedge clk);
        chk("R4 inactive no irq", int'(irq_out), 0);
        dirq = '0;

        // R8 overlap priority
        cfg(0, 'h0100, 1, 3, 1);
        cfg(1, 'h0100, 1, 5, 6);
        commit();
        io(1, 'h104, 1);
        chk("R8 lowest wins", seen_rd, 'b001);
        cfg(0, 'h0100, 0, 3, 1);
        commit();
        io(2, 'h104, 1);
        chk("R8 next device when winner off", seen_wr, 'b010);

        // R6 range limits
        cfg(2, 'h00A8, 1, 0, 0);
        commit();
        io(1, 'h0A8, 1);
        chk("R6 base below 0x100", seen_rd, 0);
        cfg(2, 'h10A8, 1, 0, 0);
        commit();
        io(1, 'h0A8, 1);
        chk("R6 base above 0xFFF", seen_rd, 0);
        cfg(2, 'h0FF8, 1, 0, 0);
        commit();
        io(2, 'h3FE, 1);
        chk("R6 top base 0xFF8 valid", seen_wr, 'b100);
        chk("R6 offset", int'(ofs), 6);

        // R12 read turning straight into write
        clr();
        @(negedge clk); addr = 10'h3F9; ior_n = 1'b0;
        @(negedge clk); ior_n = 1'b1; iow_n = 1'b0;
        @(negedge clk); iow_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 read then write rd", seen_rd, 'b100);
        chk("R12 read then write wr", seen_wr, 'b100);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule